// File: doc/BRIEF.md
# Password-Gated Clock Control Register Bank

This block is the software-facing register file of a clock controller. A host reaches it over a simple bus of valid, write, byte address and data, where each access is one 32-bit word. Every register drives a slice of a wide output vector, and the PLLs, channel dividers and clock selectors read their settings from that vector.

Writes are protected by a key. The top byte of each write word must hold a fixed magic value. A write without that value is dropped silently. A write with it is stored with the key byte cleared, so the stored top byte is always zero. After each accepted write, the block pulses a one-cycle update strobe together with the register index, so that downstream dividers know to restart.

One address is not backed by storage. A read of it returns live lock flags for five PLLs. Each flag is derived from a power-down bit and an analog-reset bit held in that PLL's own registers.

Top module: `clkmgr_regbank`

## Requirements
- R1: After reset every stored register reads zero, the whole `reg_q` vector is zero and `upd_valid` is low.
- R2: A write is accepted when `bus_wdata[31:24]` equals 0x5A and the access is otherwise valid. The register at index `bus_addr[12:2]` then takes `{8'h00, bus_wdata[23:0]}`. This value appears on `reg_q[32*i +: 32]` after the clock edge that takes the write.
- R3: A write whose bits [31:24] differ from 0x5A leaves every register unchanged and raises no strobe.
- R4: An access with `bus_addr[1:0]` not zero is rejected. Such a write changes nothing, and such a read returns zero.
- R5: A read of index 2 returns the lock word. For PLL p (0 to 4), bit 8+p is set exactly when bit 16 of register 16+p (power-down) is clear and bit 8 of register 8+p (analog reset) is clear. All other bits of the lock word are zero.
- R6: A write to index 2 is dropped. The stored slot for index 2 stays zero, no strobe is raised, and the lock word is unaffected.
- R7: A read of any other implemented index returns the stored value, with no cycle of latency. Read data depends only on the address.
- R8: In the cycle after each accepted write, `upd_valid` is high for exactly one cycle and `upd_index` carries the written index. The strobe is low after any rejected access.
- R9: Only indices below 64 are implemented. A write to a higher index inside the 0x2000-byte window is dropped, and a read of one returns zero.
- R10: The lock word follows register contents at once: a read in the cycle after a write to a power-down or analog-reset bit already shows the new flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 13 | Byte address within the window |
| bus_wdata | input | 32 | Write word, key in bits [31:24] |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| reg_q | output | 2048 | All stored registers, index i at bits [32*i +: 32] |
| upd_valid | output | 1 | One-cycle pulse after an accepted write |
| upd_index | output | 11 | Index of the register just written |

## Verification
The checker assumes that `bus_write` is meaningful only while `bus_valid` is high. It also assumes that the bus inputs are steady around the rising edge. The checker does not depend on the order of accesses. The bench meets these assumptions by changing every input on the falling edge. Each access is issued as a single cycle, and the request is dropped before the next one begins. Reads are sampled a moment after the address settles, which keeps them on the combinational read path.

// File: rtl/clkmgr_regbank.sv
module clkmgr_regbank #(
  parameter int NUM_REGS   = 64,
  parameter int ADDR_W     = 13,
  parameter int NUM_PLL    = 5,
  parameter logic [7:0] KEY = 8'h5A,
  parameter int LOCK_IDX   = 2,
  parameter int RST_BASE   = 8,
  parameter int CTRL_BASE  = 16,
  parameter int PWRDN_BIT  = 16,
  parameter int ARST_BIT   = 8,
  parameter int LOCK_SHIFT = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_valid,
  input  logic                     bus_write,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  output logic [NUM_REGS*32-1:0]   reg_q,
  output logic                     upd_valid,
  output logic [ADDR_W-3:0]        upd_index
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int SEL_W = $clog2(NUM_REGS);

  logic [31:0]      regs [NUM_REGS];
  logic [IDX_W-1:0] idx;
  logic [SEL_W-1:0] sel;
  logic             aligned, in_range, key_ok, is_lock, accept;
  logic [NUM_PLL-1:0] lock_bits;
  logic [31:0]      lock_word;

  assign idx      = bus_addr[ADDR_W-1:2];
  assign sel      = idx[SEL_W-1:0];
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign in_range = ({1'b0, idx} < (IDX_W+1)'(NUM_REGS));
  assign key_ok   = (bus_wdata[31:24] == KEY);
  assign is_lock  = (idx == IDX_W'(LOCK_IDX));
  assign accept   = bus_valid && bus_write && aligned && in_range && key_ok && !is_lock;

  for (genvar p = 0; p < NUM_PLL; p++) begin : g_lock
    assign lock_bits[p] = !regs[CTRL_BASE+p][PWRDN_BIT] && !regs[RST_BASE+p][ARST_BIT];
  end
  assign lock_word = 32'(lock_bits) << LOCK_SHIFT;

  always_comb begin
    if (!aligned || !in_range) bus_rdata = '0;
    else if (is_lock)          bus_rdata = lock_word;
    else                       bus_rdata = regs[sel];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      upd_valid <= 1'b0;
      upd_index <= '0;
    end else begin
      if (accept) regs[sel] <= {8'h00, bus_wdata[23:0]};
      upd_valid <= accept;
      if (accept) upd_index <= idx;
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_out
    assign reg_q[i*32 +: 32] = regs[i];
  end
endmodule

// File: rtl/clkmgr_regbank_chk.sv
module clkmgr_regbank_chk #(
  parameter int NUM_REGS = 64,
  parameter int ADDR_W   = 13,
  parameter int LOCK_IDX = 2,
  parameter logic [7:0] KEY = 8'h5A
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_valid,
  input logic                   bus_write,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [31:0]            bus_wdata,
  input logic [31:0]            bus_rdata,
  input logic [NUM_REGS*32-1:0] reg_q,
  input logic                   upd_valid,
  input logic [ADDR_W-3:0]      upd_index
);
  logic key_top_dirty;
  always_comb begin
    key_top_dirty = 1'b0;
    for (int i = 0; i < NUM_REGS; i++) key_top_dirty |= |reg_q[i*32+24 +: 8];
  end

  a_r2_key_byte_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !key_top_dirty);

  a_r3_bad_key_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && bus_wdata[31:24] != KEY |=> $stable(reg_q));

  a_r4_unaligned_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && bus_addr[1:0] != 2'b00 |=> $stable(reg_q));

  a_r4_unaligned_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr[1:0] != 2'b00 |-> bus_rdata == 32'h0);

  a_r6_lock_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(LOCK_IDX) |=> $stable(reg_q));

  a_r8_strobe_after_keyed_write: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> $past(bus_valid && bus_write && bus_wdata[31:24] == KEY && bus_addr[1:0] == 2'b00));

  a_r8_strobe_index: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> upd_index == $past(bus_addr[ADDR_W-1:2]));
endmodule

bind clkmgr_regbank clkmgr_regbank_chk #(
  .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .LOCK_IDX(LOCK_IDX), .KEY(KEY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .reg_q(reg_q), .upd_valid(upd_valid), .upd_index(upd_index)
);

// File: tb/tb_clkmgr_regbank.sv
module tb_clkmgr_regbank;
  localparam int CLK_P = 10;
  localparam int NR = 64;

  logic clk = 0, rst_n = 0, bus_valid = 0, bus_write = 0;
  logic [12:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NR*32-1:0] reg_q;
  logic upd_valid;
  logic [10:0] upd_index;
  int checks = 0, errors = 0;

  clkmgr_regbank dut (.clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .reg_q(reg_q),
    .upd_valid(upd_valid), .upd_index(upd_index));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] rq(input int i);
    return reg_q[i*32 +: 32];
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    chk(reg_q == '0, "R1 all regs zero", 32'(|reg_q), 0);
    chk(!upd_valid, "R1 strobe low", 32'(upd_valid), 0);
    rd(13'h008, d);
    chk(d == 32'h1F00, "R5 lock after reset", d, 32'h1F00);
  endtask

  task automatic t_store();
    logic [31:0] d;
    wr(13'h014, 32'h5A123456);
    chk(upd_valid && upd_index == 5, "R8 strobe idx", {upd_valid, 20'h0, upd_index}, {1'b1, 20'h0, 11'd5});
    chk(rq(5) == 32'h00123456, "R2 stored stripped", rq(5), 32'h00123456);
    rd(13'h014, d);
    chk(d == 32'h00123456, "R7 readback", d, 32'h00123456);
    @(negedge clk);
    chk(!upd_valid, "R8 single cycle", 32'(upd_valid), 0);
    wr(13'h018, 32'h5AFFFFFF);
    chk(rq(6) == 32'h00FFFFFF, "R2 top byte cleared", rq(6), 32'h00FFFFFF);
  endtask

  task automatic t_badkey();
    wr(13'h014, 32'hA5FFFFFF);
    chk(rq(5) == 32'h00123456, "R3 bad key kept", rq(5), 32'h00123456);
    chk(!upd_valid, "R3 no strobe", 32'(upd_valid), 0);
  endtask

  task automatic t_unaligned();
    logic [31:0] d;
    wr(13'h016, 32'h5A000001);
    chk(rq(5) == 32'h00123456, "R4 unaligned write dropped", rq(5), 32'h00123456);
    chk(!upd_valid, "R4 no strobe", 32'(upd_valid), 0);
    rd(13'h015, d);
    chk(d == 0, "R4 unaligned read zero", d, 0);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    wr(13'h044, 32'h5A010000);
    rd(13'h008, d);
    chk(d == 32'h1D00, "R10 pll1 powered down", d, 32'h1D00);
    wr(13'h02C, 32'h5A000100);
    rd(13'h008, d);
    chk(d == 32'h1500, "R5 pll3 analog reset", d, 32'h1500);
    wr(13'h050, 32'h5A00FEFF);
    rd(13'h008, d);
    chk(d == 32'h1500, "R5 other bits ignored", d, 32'h1500);
    wr(13'h044, 32'h5A000000);
    rd(13'h008, d);
    chk(d == 32'h1700, "R10 pll1 relocked", d, 32'h1700);
  endtask

  task automatic t_lockwr();
    logic [31:0] d;
    wr(13'h008, 32'h5A0000FF);
    chk(rq(2) == 0, "R6 lock slot unchanged", rq(2), 0);
    chk(!upd_valid, "R6 no strobe", 32'(upd_valid), 0);
    rd(13'h008, d);
    chk(d == 32'h1700, "R6 lock word unaffected", d, 32'h1700);
  endtask

  task automatic t_range();
    logic [31:0] d;
    logic [NR*32-1:0] snap;
    snap = reg_q;
    wr(13'h0190, 32'h5A00ABCD);
    chk(reg_q == snap, "R9 high index write dropped", 32'(reg_q != snap), 0);
    chk(!upd_valid, "R9 no strobe", 32'(upd_valid), 0);
    rd(13'h0190, d);
    chk(d == 0, "R9 high index read zero", d, 0);
    wr(13'h00FC, 32'h5A00BEEF);
    chk(upd_valid && upd_index == 63, "R8 last index strobe", {21'h0, upd_index}, 63);
    rd(13'h00FC, d);
    chk(d == 32'h0000BEEF, "R7 last index readback", d, 32'h0000BEEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_store();
    t_badkey();
    t_unaligned();
    t_lock();
    t_lockwr();
    t_range();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule